// File: doc/BRIEF.md
# I3C Target Common-Command Decoder

This block sits behind the bus engine of an I3C target and handles common command codes once they have been deframed. For each code it records the byte, works out whether the command is addressed to all targets or to selected targets, and checks it against the fixed set of codes that the target understands. The result is reported through sticky interrupt flags that software clears by writing ones. Any code, including an unknown one, is kept in a capture register, so software can serve unknown commands itself.

Supported write commands also change local configuration. Enable-events and disable-events commands change the hot-join and in-band-interrupt enables. Reset-dynamic-address drops the valid bit of the current dynamic address. Set-max-read-length and set-max-write-length load the length registers and the in-band-interrupt payload size. For directed read commands, the block names the register group that the serialiser should send back. Bus signalling, address arbitration and read-data shifting are left to neighbouring logic.

A transaction opens on `cmd_vld` and closes on `cmd_done`. While it is open, address phases (`adr_vld`) and payload bytes (`wr_vld`) belong to the command. Address phases seen outside a command are ordinary private-transfer address matches.

Top module: `ccc_target_decoder`

## Requirements
- R1: On every `cmd_vld`, `cap_code` holds `cmd_code` from the next cycle onward, whether or not the code is supported.
- R2: A code with bit 7 clear is a broadcast command. In the cycle after `cmd_vld`, exactly one flag is set: `flags[0]` if the code is one of 0x00, 0x01, 0x06, 0x07, 0x09, 0x0A, 0x0C or 0x2A, and `flags[1]` otherwise.
- R3: A code with bit 7 set is a direct command. It sets no flag when the code arrives. An address phase inside the command that has `adr_hit`=1 sets, in the following cycle, `flags[0]` if the code is one of 0x80, 0x81, 0x86, 0x88, 0x89, 0x8A, 0x8B, 0x8C, 0x8D, 0x8E, 0x8F, 0x90, 0x94 or 0x9A, and `flags[1]` otherwise. An address phase with `adr_hit`=0 sets no flag.
- R4: Address phases inside a command never set `flags[2]` (static match) or `flags[3]` (dynamic match). Outside a command, a matching address phase sets `flags[2]` when `adr_dyn`=0 and `flags[3]` when `adr_dyn`=1.
- R5: The flags are sticky. A cycle with `clr_we`=1 clears the flag bits set in `clr_mask`. A flag set in the same cycle as a clear stays set.
- R6: The first payload byte of enable-events (0x00/0x80) sets the enables, and that of disable-events (0x01/0x81) clears them. Bit 0 of the byte selects `ibi_en` and bit 3 selects `hj_en`; the other bits have no effect. Both enables are 1 after reset.
- R7: `da_assign` sets `dyn_adr_vld`. Broadcast 0x06 clears it as the code arrives. Direct 0x86 clears it on a matching address phase and not on a missed one.
- R8: Set-max-read-length (0x0A/0x8A) takes the most significant byte first. `rd_len` is loaded when the second byte arrives, and a third byte loads `ibi_size`. Set-max-write-length (0x09/0x89) loads `wr_len` from two bytes in the same order.
- R9: Payload bytes change nothing in these cases: outside a command, for unsupported codes, in a direct command whose last address phase missed, or beyond the bytes that the command defines.
- R10: While a direct command is open and its last address phase matched, `get_sel` names the read source: 1 for 0x8D, 2 for 0x8E, 3 for 0x8F, 4 for 0x90, 5 for 0x8C, 6 for 0x8B, 7 for 0x94, 8 for 0x9A. For any other code or state it is 0.
- R11: `cmd_done` closes the command. From the next cycle, `in_ccc` and `get_sel` are 0, payload bytes are ignored, and address phases are private matches again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_vld | input | 1 | Command code strobe; opens a command |
| cmd_code | input | 8 | Command code byte |
| cmd_done | input | 1 | Closes the current command |
| adr_vld | input | 1 | Address phase strobe |
| adr_hit | input | 1 | Address phase matched this target |
| adr_dyn | input | 1 | The match was on the dynamic address (1) or the static address (0) |
| wr_vld | input | 1 | Payload byte strobe |
| wr_byte | input | 8 | Payload byte |
| da_assign | input | 1 | A dynamic address was assigned |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 4 | Flag bits to clear |
| cap_code | output | 8 | Last captured command code |
| flags | output | 4 | Sticky flags: supported, unsupported, static match, dynamic match |
| in_ccc | output | 1 | A command is open |
| hj_en | output | 1 | Hot-join enable |
| ibi_en | output | 1 | In-band interrupt enable |
| dyn_adr_vld | output | 1 | Dynamic address valid |
| rd_len | output | 16 | Maximum read length |
| ibi_size | output | 8 | In-band interrupt payload size |
| wr_len | output | 16 | Maximum write length |
| get_sel | output | 4 | Read-data source for a directed read |

## Verification
The hardest case to reach is a direct command whose flags and side effects depend on its address phase, not on its code. This is worst when the same command holds a missed phase followed by a matching one. The stimulus sweeps all 256 codes, and each direct code is followed by a matching phase. Targeted sequences then add a missed phase, payload bytes sent before and after the matching phase, and a flag clear that lands in the same cycle as a new set.

// File: rtl/ccc_pkg.sv
package ccc_pkg;

  localparam int FLAG_W   = 4;
  localparam int FL_SUP   = 0;
  localparam int FL_UNS   = 1;
  localparam int FL_SADR  = 2;
  localparam int FL_DADR  = 3;

  typedef enum logic [3:0] {
    GS_NONE   = 4'd0,
    GS_PID    = 4'd1,
    GS_BCR    = 4'd2,
    GS_DCR    = 4'd3,
    GS_STAT   = 4'd4,
    GS_MRL    = 4'd5,
    GS_MWL    = 4'd6,
    GS_MXDS   = 4'd7,
    GS_RSTACT = 4'd8
  } get_src_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_EVT_ON,
    OP_EVT_OFF,
    OP_DA_RESET,
    OP_SET_RD,
    OP_SET_WR,
    OP_OTHER
  } op_e;

  function automatic logic code_is_direct(input logic [7:0] c);
    return c[7];
  endfunction

  function automatic logic code_known(input logic [7:0] c);
    case (c)
      8'h00, 8'h01, 8'h06, 8'h07, 8'h09, 8'h0A, 8'h0C, 8'h2A: return 1'b1;
      8'h80, 8'h81, 8'h86, 8'h88, 8'h89, 8'h8A, 8'h8B, 8'h8C,
      8'h8D, 8'h8E, 8'h8F, 8'h90, 8'h94, 8'h9A:               return 1'b1;
      default:                                                return 1'b0;
    endcase
  endfunction

  function automatic op_e code_op(input logic [7:0] c);
    if (!code_known(c)) return OP_NONE;
    case (c[6:0])
      7'h00:   return OP_EVT_ON;
      7'h01:   return OP_EVT_OFF;
      7'h06:   return OP_DA_RESET;
      7'h0A:   return OP_SET_RD;
      7'h09:   return OP_SET_WR;
      default: return OP_OTHER;
    endcase
  endfunction

  function automatic get_src_e code_get(input logic [7:0] c);
    case (c)
      8'h8D:   return GS_PID;
      8'h8E:   return GS_BCR;
      8'h8F:   return GS_DCR;
      8'h90:   return GS_STAT;
      8'h8C:   return GS_MRL;
      8'h8B:   return GS_MWL;
      8'h94:   return GS_MXDS;
      8'h9A:   return GS_RSTACT;
      default: return GS_NONE;
    endcase
  endfunction

  // Event enable update: {hj, ibi} with selected bits set or cleared
  function automatic logic [1:0] evt_next(input logic [1:0] cur,
                                          input logic       hj_sel,
                                          input logic       ibi_sel,
                                          input logic       turn_on);
    logic [1:0] m;
    m = {hj_sel, ibi_sel};
    return turn_on ? (cur | m) : (cur & ~m);
  endfunction

endpackage

// File: rtl/ccc_classify.sv
module ccc_classify
  import ccc_pkg::*;
(
  input  logic [7:0] code,
  output logic       direct,
  output logic       known,
  output op_e        op,
  output get_src_e   get
);
  always_comb begin
    direct = code_is_direct(code);
    known  = code_known(code);
    op     = code_op(code);
    get    = code_get(code);
  end
endmodule

// File: rtl/ccc_txn.sv
module ccc_txn #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic             in_direct,
  input  logic             cmd_done,
  input  logic             adr_vld,
  input  logic             adr_hit,
  input  logic             cap_direct,
  input  logic             wr_vld,
  output logic             in_ccc,
  output logic             sel,
  output logic [IDX_W-1:0] idx,
  output logic             pay_take
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic adr_in_cmd;

  always_comb begin
    adr_in_cmd = adr_vld && in_ccc && cap_direct && !cmd_vld;
    pay_take   = wr_vld && in_ccc && sel && !cmd_vld && !adr_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ccc <= 1'b0;
      sel    <= 1'b0;
      idx    <= '0;
    end else begin
      if (cmd_vld) begin
        in_ccc <= 1'b1;
        sel    <= !in_direct;
        idx    <= '0;
      end else if (cmd_done) begin
        in_ccc <= 1'b0;
        sel    <= 1'b0;
        idx    <= '0;
      end else if (adr_in_cmd) begin
        sel    <= adr_hit;
        idx    <= '0;
      end else if (pay_take && idx != IDX_MAX) begin
        idx    <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ccc_flags.sv
module ccc_flags #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] set_vec,
  input  logic          clr_we,
  input  logic [FW-1:0] clr_mask,
  output logic [FW-1:0] flags
);
  logic [FW-1:0] clr_eff;

  always_comb clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_eff) | set_vec;
  end
endmodule

// File: rtl/ccc_cfg.sv
module ccc_cfg
  import ccc_pkg::*;
#(
  parameter int             LEN_W       = 16,
  parameter int             IBI_W       = 8,
  parameter int             IDX_W       = 2,
  parameter int             EVT_IBI_BIT = 0,
  parameter int             EVT_HJ_BIT  = 3,
  parameter logic [LEN_W-1:0] RST_RD    = 16'h0100,
  parameter logic [LEN_W-1:0] RST_WR    = 16'h0100,
  parameter logic [IBI_W-1:0] RST_IBI   = 8'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pay_take,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       pay_byte,
  input  op_e              op,
  input  logic             da_reset,
  input  logic             da_assign,
  output logic             hj_en,
  output logic             ibi_en,
  output logic             dyn_adr_vld,
  output logic [LEN_W-1:0] rd_len,
  output logic [IBI_W-1:0] ibi_size,
  output logic [LEN_W-1:0] wr_len
);
  localparam int HI_W = LEN_W - 8;

  logic [HI_W-1:0] hi_stage;
  logic [1:0]      evt_nx;
  logic            take0, take1, take2;

  always_comb begin
    take0  = pay_take && (idx == IDX_W'(0));
    take1  = pay_take && (idx == IDX_W'(1));
    take2  = pay_take && (idx == IDX_W'(2));
    evt_nx = evt_next({hj_en, ibi_en}, pay_byte[EVT_HJ_BIT],
                      pay_byte[EVT_IBI_BIT], op == OP_EVT_ON);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hj_en       <= 1'b1;
      ibi_en      <= 1'b1;
      dyn_adr_vld <= 1'b0;
      rd_len      <= RST_RD;
      wr_len      <= RST_WR;
      ibi_size    <= RST_IBI;
      hi_stage    <= '0;
    end else begin
      if (da_reset)       dyn_adr_vld <= 1'b0;
      else if (da_assign) dyn_adr_vld <= 1'b1;

      if (take0 && (op == OP_EVT_ON || op == OP_EVT_OFF))
        {hj_en, ibi_en} <= evt_nx;

      if (take0 && (op == OP_SET_RD || op == OP_SET_WR))
        hi_stage <= pay_byte[HI_W-1:0];

      if (take1 && op == OP_SET_RD) rd_len <= {hi_stage, pay_byte};
      if (take1 && op == OP_SET_WR) wr_len <= {hi_stage, pay_byte};
      if (take2 && op == OP_SET_RD) ibi_size <= pay_byte[IBI_W-1:0];
    end
  end
endmodule

// File: rtl/ccc_target_decoder.sv
module ccc_target_decoder
  import ccc_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int IBI_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic [7:0]       cmd_code,
  input  logic             cmd_done,
  input  logic             adr_vld,
  input  logic             adr_hit,
  input  logic             adr_dyn,
  input  logic             wr_vld,
  input  logic [7:0]       wr_byte,
  input  logic             da_assign,
  input  logic             clr_we,
  input  logic [3:0]       clr_mask,
  output logic [7:0]       cap_code,
  output logic [3:0]       flags,
  output logic             in_ccc,
  output logic             hj_en,
  output logic             ibi_en,
  output logic             dyn_adr_vld,
  output logic [LEN_W-1:0] rd_len,
  output logic [IBI_W-1:0] ibi_size,
  output logic [LEN_W-1:0] wr_len,
  output logic [3:0]       get_sel
);
  localparam int IDX_W = 2;

  logic       in_direct, in_known, cap_direct, cap_known;
  op_e        in_op, cap_op;
  get_src_e   in_get, cap_get;
  logic       sel, pay_take;
  logic [IDX_W-1:0] idx;

  // Named events for the checker
  logic             bc_evt, dc_evt, prv_hit, da_reset;
  logic [FLAG_W-1:0] set_vec;

  ccc_classify u_cls_in (
    .code(cmd_code), .direct(in_direct), .known(in_known),
    .op(in_op), .get(in_get)
  );

  ccc_classify u_cls_cap (
    .code(cap_code), .direct(cap_direct), .known(cap_known),
    .op(cap_op), .get(cap_get)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_code <= '0;
    else if (cmd_vld) cap_code <= cmd_code;
  end

  ccc_txn #(.IDX_W(IDX_W)) u_txn (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .in_direct(in_direct),
    .cmd_done(cmd_done), .adr_vld(adr_vld), .adr_hit(adr_hit),
    .cap_direct(cap_direct), .wr_vld(wr_vld), .in_ccc(in_ccc),
    .sel(sel), .idx(idx), .pay_take(pay_take)
  );

  always_comb begin
    bc_evt   = cmd_vld && !in_direct;
    dc_evt   = adr_vld && adr_hit && in_ccc && cap_direct && !cmd_vld;
    prv_hit  = adr_vld && adr_hit && !in_ccc && !cmd_vld;
    da_reset = (bc_evt && in_op == OP_DA_RESET) ||
               (dc_evt && cap_op == OP_DA_RESET);
    set_vec          = '0;
    set_vec[FL_SUP]  = (bc_evt && in_known)  || (dc_evt && cap_known);
    set_vec[FL_UNS]  = (bc_evt && !in_known) || (dc_evt && !cap_known);
    set_vec[FL_SADR] = prv_hit && !adr_dyn;
    set_vec[FL_DADR] = prv_hit && adr_dyn;
    get_sel  = (in_ccc && sel && cap_direct) ? cap_get : GS_NONE;
  end

  ccc_flags #(.FW(FLAG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_we(clr_we), .clr_mask(clr_mask), .flags(flags)
  );

  ccc_cfg #(.LEN_W(LEN_W), .IBI_W(IBI_W), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .pay_take(pay_take), .idx(idx),
    .pay_byte(wr_byte), .op(cap_op), .da_reset(da_reset),
    .da_assign(da_assign), .hj_en(hj_en), .ibi_en(ibi_en),
    .dyn_adr_vld(dyn_adr_vld), .rd_len(rd_len), .ibi_size(ibi_size),
    .wr_len(wr_len)
  );
endmodule

// File: rtl/ccc_target_decoder_chk.sv
module ccc_target_decoder_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_vld,
  input logic [7:0]       cmd_code,
  input logic             adr_vld,
  input logic             wr_vld,
  input logic             clr_we,
  input logic [3:0]       clr_mask,
  input logic [7:0]       cap_code,
  input logic [3:0]       flags,
  input logic             in_ccc,
  input logic             hj_en,
  input logic             ibi_en,
  input logic             dyn_adr_vld,
  input logic [LEN_W-1:0] rd_len,
  input logic [3:0]       get_sel,
  input logic [3:0]       set_vec
);
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> cap_code == $past(cmd_code));

  p_bcast_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_code[7]) |=> (flags[0] || flags[1]));

  p_one_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_vec[0] && set_vec[1]));

  p_direct_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_code[7] && !adr_vld && !clr_we) |=> $stable(flags[1:0]));

  p_no_adr_in_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ccc && !clr_we) |=> $stable(flags[3:2]));

  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !cmd_vld && !adr_vld) |=> ((flags & $past(clr_mask)) == 4'd0));

  p_evt_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({hj_en, ibi_en}) |-> $past(wr_vld && in_ccc));

  p_da_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dyn_adr_vld) |-> $past(in_ccc || cmd_vld));

  p_len_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_len) |-> $past(wr_vld && in_ccc));

  p_get_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ccc |-> get_sel == 4'd0);
endmodule

bind ccc_target_decoder ccc_target_decoder_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
  .adr_vld(adr_vld), .wr_vld(wr_vld), .clr_we(clr_we), .clr_mask(clr_mask),
  .cap_code(cap_code), .flags(flags), .in_ccc(in_ccc), .hj_en(hj_en),
  .ibi_en(ibi_en), .dyn_adr_vld(dyn_adr_vld), .rd_len(rd_len),
  .get_sel(get_sel), .set_vec(set_vec)
);

// File: tb/sim_ccc_target_decoder.sv
module sim_ccc_target_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_vld = 0, cmd_done = 0, adr_vld = 0, adr_hit = 0, adr_dyn = 0;
  logic        wr_vld = 0, da_assign = 0, clr_we = 0;
  logic [7:0]  cmd_code = 0, wr_byte = 0;
  logic [3:0]  clr_mask = 0;
  logic [7:0]  cap_code;
  logic [3:0]  flags, get_sel;
  logic        in_ccc, hj_en, ibi_en, dyn_adr_vld;
  logic [15:0] rd_len, wr_len;
  logic [7:0]  ibi_size;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ccc_target_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
    .cmd_done(cmd_done), .adr_vld(adr_vld), .adr_hit(adr_hit),
    .adr_dyn(adr_dyn), .wr_vld(wr_vld), .wr_byte(wr_byte),
    .da_assign(da_assign), .clr_we(clr_we), .clr_mask(clr_mask),
    .cap_code(cap_code), .flags(flags), .in_ccc(in_ccc), .hj_en(hj_en),
    .ibi_en(ibi_en), .dyn_adr_vld(dyn_adr_vld), .rd_len(rd_len),
    .ibi_size(ibi_size), .wr_len(wr_len), .get_sel(get_sel)
  );

  int sup_list[22] = '{'h00, 'h01, 'h06, 'h07, 'h09, 'h0A, 'h0C, 'h2A,
                       'h80, 'h81, 'h86, 'h88, 'h89, 'h8A, 'h8B, 'h8C,
                       'h8D, 'h8E, 'h8F, 'h90, 'h94, 'h9A};

  function automatic bit is_sup(int c);
    foreach (sup_list[i]) if (sup_list[i] == c) return 1;
    return 0;
  endfunction

  function automatic int exp_get(int c);
    int tbl[8] = '{'h8D, 'h8E, 'h8F, 'h90, 'h8C, 'h8B, 'h94, 'h9A};
    foreach (tbl[i]) if (tbl[i] == c) return i + 1;
    return 0;
  endfunction

  task automatic check(input longint act, input longint exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    cmd_vld = 1; cmd_code = c; tick(); cmd_vld = 0;
  endtask

  task automatic send_adr(input logic hit, input logic dyn);
    adr_vld = 1; adr_hit = hit; adr_dyn = dyn; tick(); adr_vld = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    wr_vld = 1; wr_byte = b; tick(); wr_vld = 0;
  endtask

  task automatic send_done();
    cmd_done = 1; tick(); cmd_done = 0;
  endtask

  task automatic clear(input logic [3:0] m);
    clr_we = 1; clr_mask = m; tick(); clr_we = 0;
  endtask

  task automatic assign_da();
    da_assign = 1; tick(); da_assign = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // Reset state
    check(cap_code, 0, "R1 reset capture");
    check(flags, 0, "R5 reset flags");
    check({hj_en, ibi_en}, 2'b11, "R6 reset enables");
    check(dyn_adr_vld, 0, "R7 reset valid");
    check(rd_len, 16'h0100, "R8 reset rd_len");
    check(wr_len, 16'h0100, "R8 reset wr_len");
    check(ibi_size, 8'h08, "R8 reset ibi_size");
    check(get_sel, 0, "R10 reset get_sel");

    // Sweep of every code
    for (int c = 0; c < 256; c++) begin
      clear(4'hF);
      send_cmd(8'(c));
      check(cap_code, c, "R1 capture");
      if (c < 'h80) begin
        check(flags, is_sup(c) ? 1 : 2, "R2 broadcast flag");
      end else begin
        check(flags, 0, "R3 direct no flag at code");
        send_adr(1'b1, c[0]);
        check(flags, is_sup(c) ? 1 : 2, "R3 direct flag on match");
        check(flags[3:2], 0, "R4 no address flag in command");
        check(get_sel, exp_get(c), "R10 read source");
      end
      send_done();
      check(get_sel, 0, "R11 get_sel closed");
      check(in_ccc, 0, "R11 in_ccc closed");
    end

    // Direct miss
    clear(4'hF);
    send_cmd(8'h8F); send_adr(1'b0, 1'b0);
    check(flags, 0, "R3 miss no flag");
    check(get_sel, 0, "R10 miss no source");
    send_done();

    // Address flags in and out of a command
    send_adr(1'b1, 1'b0);
    check(flags, 4'b0100, "R4 static match outside");
    send_adr(1'b1, 1'b1);
    check(flags, 4'b1100, "R4 dynamic match outside");
    clear(4'hF);
    send_cmd(8'h07); clear(4'h1);
    send_adr(1'b1, 1'b0); send_adr(1'b1, 1'b1);
    check(flags, 0, "R4 no address flag in broadcast command");
    send_done();
    send_adr(1'b1, 1'b1);
    check(flags, 4'b1000, "R11 private match after close");

    // W1C and set-over-clear
    clear(4'hF);
    send_cmd(8'h00); send_done();
    clear(4'b0010);
    check(flags, 1, "R5 other bit clear keeps flag");
    clear(4'b0001);
    check(flags, 0, "R5 clear");
    cmd_vld = 1; cmd_code = 8'h01; clr_we = 1; clr_mask = 4'h1; tick();
    cmd_vld = 0; clr_we = 0;
    check(flags, 1, "R5 set wins over clear");
    send_done();
    cmd_vld = 1; cmd_code = 8'h3F; clr_we = 1; clr_mask = 4'hF; tick();
    cmd_vld = 0; clr_we = 0;
    check(flags, 2, "R5 new unsupported set with full clear");
    send_done();

    // Event enables
    send_cmd(8'h01); send_byte(8'h01);
    check({hj_en, ibi_en}, 2'b10, "R6 disable ibi");
    send_done();
    send_cmd(8'h01); send_byte(8'h08);
    check({hj_en, ibi_en}, 2'b00, "R6 disable hj");
    send_done();
    send_cmd(8'h80); send_adr(1'b1, 1'b1); send_byte(8'h01);
    check({hj_en, ibi_en}, 2'b01, "R6 direct enable ibi");
    send_byte(8'h08);
    check({hj_en, ibi_en}, 2'b01, "R9 second event byte ignored");
    send_done();
    send_cmd(8'h00); send_byte(8'hF6);
    check({hj_en, ibi_en}, 2'b01, "R6 other bits no effect");
    send_done();
    send_cmd(8'h81); send_adr(1'b0, 1'b0); send_byte(8'h09);
    check({hj_en, ibi_en}, 2'b01, "R9 missed direct ignored");
    send_done();

    // Dynamic address reset
    assign_da();
    check(dyn_adr_vld, 1, "R7 assign");
    send_cmd(8'h06);
    check(dyn_adr_vld, 0, "R7 broadcast reset");
    send_done(); assign_da();
    send_cmd(8'h86);
    check(dyn_adr_vld, 1, "R7 direct waits for address");
    send_adr(1'b0, 1'b0);
    check(dyn_adr_vld, 1, "R7 direct miss keeps");
    send_adr(1'b1, 1'b1);
    check(dyn_adr_vld, 0, "R7 direct hit resets");
    send_done();

    // Lengths
    send_cmd(8'h0A); send_byte(8'h12);
    check(rd_len, 16'h0100, "R8 rd_len waits for low byte");
    send_byte(8'h34);
    check(rd_len, 16'h1234, "R8 rd_len");
    send_byte(8'h56);
    check(ibi_size, 8'h56, "R8 ibi_size");
    send_byte(8'h77);
    check(ibi_size, 8'h56, "R9 extra byte ignored");
    check(rd_len, 16'h1234, "R9 extra byte rd_len");
    send_done();
    send_cmd(8'h89); send_adr(1'b0, 1'b0); send_byte(8'h11); send_byte(8'h22);
    check(wr_len, 16'h0100, "R9 miss no write length");
    send_adr(1'b1, 1'b0); send_byte(8'hAB); send_byte(8'hCD);
    check(wr_len, 16'hABCD, "R8 wr_len after later match");
    send_done();
    send_cmd(8'h20); send_byte(8'h99); send_byte(8'h88);
    check(wr_len, 16'hABCD, "R9 unsupported payload");
    check(rd_len, 16'h1234, "R9 unsupported payload rd");
    send_done();
    send_byte(8'h44); send_byte(8'h55);
    check(rd_len, 16'h1234, "R11 payload after close");
    check(wr_len, 16'hABCD, "R9 payload outside command");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule